// File: doc/BRIEF.md
# ATA Device Protocol Engine

This block is the device-side command sequencer of an ATA disk. A host-side register decoder turns bus accesses into one-cycle strobes: status read, command write, device-select write, device-control write, and data-port word reads and writes. A media model reports when a sector buffer is ready and when a DMA burst has finished. The engine responds by keeping the status byte, driving the interrupt request line, and tracking how many bytes remain in the current command and in the current block.

The engine supports four things. It has selected, unselected and interrupt-pending idle states. It handles software reset through the control register. It tracks interrupt enable, which is captured on every control write. It sequences three kinds of command: PIO data-in, PIO data-out and DMA. Each block holds a parameterised number of bytes, one sector. Each data strobe moves one word. A sector count of zero means the largest count, and only LBA-addressed data commands are accepted.

Top module: `ata_dev_engine`

## Requirements
- R1: After reset, status is 0x40 (ready only), the interrupt line is low, and both byte counters read zero. The device with id 0 starts selected.
- R2: In selected idle with no interrupt pending, a command write with opcode 0x20 (PIO in), 0x30 (PIO out), 0xC8 or 0xCA (DMA), with the LBA flag set, is accepted. Acceptance sets busy (0x80) and clears data request (0x08), device fault (0x20) and error (0x01). It also loads the command byte counter with count × SECT_BYTES, where a count of 0 stands for MAX_SECT.
- R3: An opcode outside that set, or a data command without the LBA flag, gives status 0x41 (ready plus error) and leaves the device idle. A following data-ready event then changes nothing.
- R4: A data-ready event in a prepare state clears busy, sets data request and reloads the block counter to SECT_BYTES. Busy and data request are never set together.
- R5: In PIO transfers, each data word strobe lowers both counters by WORD_BYTES. In data-in, each ready block raises the interrupt when interrupts are enabled. When a data-in block ends with bytes still left, busy is set and data request is cleared. When the last word is read, status becomes 0x50 and no interrupt is raised.
- R6: A status read clears a pending interrupt, and the line is low in the next cycle.
- R7: A select write naming the other device drops the interrupt line and moves the idle device to the unselected state. A select write that names this device again, while an interrupt is pending and enabled, raises the line again.
- R8: While the control register's interrupt-disable bit (nien) is set, the line stays low. Setting that bit discards a pending interrupt, so clearing it later does not bring the interrupt back.
- R9: A control write with the reset bit set sets busy, clears data request, zeroes the counters, and makes the device ignore command and data strobes. A later control write with the reset bit clear restores status 0x40 with no interrupt pending.
- R10: Command writes are ignored while the device is unselected or busy with another command.
- R11: In PIO data-out, the first block's data-ready raises no interrupt; later blocks raise one unless interrupts are disabled. After each written block, busy and seek (0x10) are set and data request is cleared. The data-ready that follows the last block completes the command with status 0x50 and raises an interrupt if enabled.
- R12: In DMA, the data-ready event gives data request. The DMA-done event completes with status 0x50 and raises an interrupt if enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_rd | input | 1 | Status register read strobe |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_op | input | 8 | Opcode written with cmd_wr |
| cmd_seccnt | input | $clog2(MAX_SECT) | Sector count register contents |
| cmd_lba | input | 1 | LBA addressing flag from the drive/head register |
| sel_wr | input | 1 | Device-select write strobe |
| sel_dev | input | 1 | Device number written with sel_wr |
| ctl_wr | input | 1 | Device-control write strobe |
| ctl_srst | input | 1 | Software reset bit written with ctl_wr |
| ctl_nien | input | 1 | Interrupt-disable bit written with ctl_wr |
| data_rd | input | 1 | Data port word read strobe |
| data_wr | input | 1 | Data port word write strobe |
| media_ready | input | 1 | Media model reports a block ready or accepted |
| dma_done | input | 1 | Media model reports the DMA transfer finished |
| status | output | 8 | Status byte |
| intrq | output | 1 | Interrupt request line |
| cmd_left | output | $clog2(MAX_SECT*SECT_BYTES+1) | Bytes left in the current command |
| blk_left | output | $clog2(SECT_BYTES+1) | Bytes left in the current block |

## Verification
Four properties are checked on every cycle by assertions. Busy and data request are never set together. The interrupt line is low after a status read, after a deselect, and while interrupts are disabled. No data word is counted in a block that is already drained. A rejected opcode always yields ready plus error. Some behaviour can only be shown by the bench's scenarios: the exact status value after each step of PIO-in, PIO-out and DMA sequences, across every sector count and both interrupt settings. The same holds for the special silent first data-out block, the interrupt coming back on reselection, and ignored strobes during software reset.

// File: rtl/ata_dev_pkg.sv
package ata_dev_pkg;

    typedef enum logic [3:0] {
        ST_IDLE_S,
        ST_IDLE_SI,
        ST_IDLE_NS,
        ST_SRST,
        ST_PREP_IN,
        ST_XFER_IN,
        ST_PREP_OUT,
        ST_XFER_OUT,
        ST_PREP_DMA,
        ST_XFER_DMA
    } dev_state_e;

    typedef enum logic [1:0] {
        CK_PIO_IN,
        CK_PIO_OUT,
        CK_DMA,
        CK_BAD
    } cmd_kind_e;

    typedef struct packed {
        dev_state_e  state;
        logic [7:0]  status;
        logic        sel;
        logic        nien;
        logic        pend;
        logic        intrq;
    } dev_regs_t;

    localparam logic [7:0] SB_BSY  = 8'h80;
    localparam logic [7:0] SB_RDY  = 8'h40;
    localparam logic [7:0] SB_DF   = 8'h20;
    localparam logic [7:0] SB_SEEK = 8'h10;
    localparam logic [7:0] SB_DRQ  = 8'h08;
    localparam logic [7:0] SB_ERR  = 8'h01;

    localparam logic [7:0] OP_PIO_RD = 8'h20;
    localparam logic [7:0] OP_PIO_WR = 8'h30;
    localparam logic [7:0] OP_DMA_RD = 8'hC8;
    localparam logic [7:0] OP_DMA_WR = 8'hCA;

endpackage

// File: rtl/ata_cmd_decode.sv
module ata_cmd_decode
    import ata_dev_pkg::*;
#(
    parameter int SECT_BYTES = 512,
    parameter int MAX_SECT   = 256,
    parameter int SW         = 8,
    parameter int CW         = 18
) (
    input  logic [7:0]    opcode,
    input  logic [SW-1:0] sec_cnt,
    input  logic          lba,
    output cmd_kind_e     kind,
    output logic [CW-1:0] total
);

    logic [CW-1:0] nsec;

    always_comb begin
        // zero sectors encodes the largest transfer
        nsec  = (sec_cnt == '0) ? CW'(MAX_SECT) : CW'(sec_cnt);
        total = nsec * CW'(SECT_BYTES);
        case (opcode)
            OP_PIO_RD:            kind = CK_PIO_IN;
            OP_PIO_WR:            kind = CK_PIO_OUT;
            OP_DMA_RD, OP_DMA_WR: kind = CK_DMA;
            default:              kind = CK_BAD;
        endcase
        if (!lba) kind = CK_BAD;
    end

endmodule

// File: rtl/ata_xfer_count.sv
module ata_xfer_count #(
    parameter int SECT_BYTES = 512,
    parameter int WORD_BYTES = 2,
    parameter int CW         = 18,
    parameter int BW         = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load_cmd,
    input  logic [CW-1:0] total,
    input  logic          load_blk,
    input  logic          step,
    output logic [CW-1:0] cmd_left,
    output logic [BW-1:0] blk_left,
    output logic          first_blk
);

    typedef struct packed {
        logic [CW-1:0] left;
        logic [CW-1:0] tot;
        logic [BW-1:0] blk;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else begin
            if (load_cmd) begin
                cnt_d.left = total;
                cnt_d.tot  = total;
                cnt_d.blk  = '0;
            end
            if (load_blk) cnt_d.blk = BW'(SECT_BYTES);
            if (step) begin
                cnt_d.blk  = cnt_q.blk  - BW'(WORD_BYTES);
                cnt_d.left = cnt_q.left - CW'(WORD_BYTES);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cmd_left  = cnt_q.left;
    assign blk_left  = cnt_q.blk;
    assign first_blk = (cnt_q.left == cnt_q.tot);

    // R5
    step_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (cnt_q.blk >= BW'(WORD_BYTES)));

endmodule

// File: rtl/ata_dev_engine.sv
module ata_dev_engine
    import ata_dev_pkg::*;
#(
    parameter int   SECT_BYTES = 512,
    parameter int   MAX_SECT   = 256,
    parameter int   WORD_BYTES = 2,
    parameter logic DEV_ID     = 1'b0,
    localparam int  SW = $clog2(MAX_SECT),
    localparam int  CW = $clog2(MAX_SECT * SECT_BYTES + 1),
    localparam int  BW = $clog2(SECT_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stat_rd,
    input  logic          cmd_wr,
    input  logic [7:0]    cmd_op,
    input  logic [SW-1:0] cmd_seccnt,
    input  logic          cmd_lba,
    input  logic          sel_wr,
    input  logic          sel_dev,
    input  logic          ctl_wr,
    input  logic          ctl_srst,
    input  logic          ctl_nien,
    input  logic          data_rd,
    input  logic          data_wr,
    input  logic          media_ready,
    input  logic          dma_done,
    output logic [7:0]    status,
    output logic          intrq,
    output logic [CW-1:0] cmd_left,
    output logic [BW-1:0] blk_left
);

    dev_regs_t     r_d, r_q;
    cmd_kind_e     kind;
    logic [CW-1:0] total;
    logic          first_blk;
    logic          load_cmd, load_blk, step, clr, post, sel_now;
    logic          blk_last, cmd_last;

    ata_cmd_decode #(
        .SECT_BYTES(SECT_BYTES), .MAX_SECT(MAX_SECT), .SW(SW), .CW(CW)
    ) u_dec (
        .opcode(cmd_op), .sec_cnt(cmd_seccnt), .lba(cmd_lba),
        .kind(kind), .total(total)
    );

    ata_xfer_count #(
        .SECT_BYTES(SECT_BYTES), .WORD_BYTES(WORD_BYTES), .CW(CW), .BW(BW)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_cmd(load_cmd),
        .total(total), .load_blk(load_blk), .step(step),
        .cmd_left(cmd_left), .blk_left(blk_left), .first_blk(first_blk)
    );

    function automatic logic [7:0] f_ready(input logic [7:0] s);
        return (s & ~SB_BSY) | SB_DRQ;
    endfunction

    assign blk_last = (blk_left == BW'(WORD_BYTES));
    assign cmd_last = (cmd_left == CW'(WORD_BYTES));

    always_comb begin
        r_d      = r_q;
        post     = 1'b0;
        load_cmd = 1'b0;
        load_blk = 1'b0;
        step     = 1'b0;
        clr      = 1'b0;
        sel_now  = sel_wr ? (sel_dev == DEV_ID) : r_q.sel;
        r_d.sel  = sel_now;
        if (ctl_wr) r_d.nien = ctl_nien;

        if (ctl_wr && ctl_srst) begin
            r_d.state  = ST_SRST;
            r_d.status = (r_q.status | SB_BSY) & ~SB_DRQ;
            r_d.pend   = 1'b0;
            clr        = 1'b1;
        end else begin
            case (r_q.state)
                ST_SRST: if (ctl_wr) begin
                    r_d.status = SB_RDY;
                    r_d.pend   = 1'b0;
                    clr        = 1'b1;
                    r_d.state  = ST_IDLE_S;
                end
                ST_IDLE_S, ST_IDLE_SI: begin
                    if (sel_wr && !sel_now) begin
                        r_d.state = ST_IDLE_NS;
                    end else if (r_q.state == ST_IDLE_S && cmd_wr) begin
                        if (kind == CK_BAD) begin
                            r_d.status = SB_RDY | SB_ERR;
                        end else begin
                            r_d.status = (r_q.status | SB_BSY) & ~(SB_DRQ | SB_DF | SB_ERR);
                            load_cmd   = 1'b1;
                            case (kind)
                                CK_PIO_IN:  r_d.state = ST_PREP_IN;
                                CK_PIO_OUT: r_d.state = ST_PREP_OUT;
                                default:    r_d.state = ST_PREP_DMA;
                            endcase
                        end
                    end
                end
                ST_IDLE_NS: if (sel_wr && sel_now) r_d.state = ST_IDLE_S;
                ST_PREP_IN: if (media_ready) begin
                    r_d.status = f_ready(r_q.status);
                    load_blk   = 1'b1;
                    post       = 1'b1;
                    r_d.state  = ST_XFER_IN;
                end
                ST_XFER_IN: if (data_rd) begin
                    step = 1'b1;
                    if (blk_last && cmd_last) begin
                        r_d.status = SB_RDY | SB_SEEK;
                        r_d.state  = ST_IDLE_S;
                    end else if (blk_last) begin
                        r_d.status = (r_q.status | SB_BSY) & ~SB_DRQ;
                        r_d.state  = ST_PREP_IN;
                    end
                end
                ST_PREP_OUT: if (media_ready) begin
                    if (cmd_left == '0) begin
                        r_d.status = SB_RDY | SB_SEEK;
                        post       = 1'b1;
                        r_d.state  = ST_IDLE_S;
                    end else begin
                        r_d.status = f_ready(r_q.status);
                        load_blk   = 1'b1;
                        post       = !first_blk;
                        r_d.state  = ST_XFER_OUT;
                    end
                end
                ST_XFER_OUT: if (data_wr) begin
                    step = 1'b1;
                    if (blk_last) begin
                        r_d.status = (r_q.status | SB_BSY | SB_SEEK) & ~SB_DRQ;
                        r_d.state  = ST_PREP_OUT;
                    end
                end
                ST_PREP_DMA: if (media_ready) begin
                    r_d.status = f_ready(r_q.status);
                    r_d.state  = ST_XFER_DMA;
                end
                ST_XFER_DMA: if (dma_done) begin
                    r_d.status = SB_RDY | SB_SEEK;
                    post       = 1'b1;
                    r_d.state  = ST_IDLE_S;
                end
                default: r_d.state = ST_IDLE_S;
            endcase
        end

        if (post && !r_d.nien) r_d.pend = 1'b1;
        if (stat_rd || (ctl_wr && ctl_nien)) r_d.pend = 1'b0;
        // idle flavour follows selection and pending interrupt
        if (r_d.state == ST_IDLE_S || r_d.state == ST_IDLE_SI)
            r_d.state = !r_d.sel ? ST_IDLE_NS : (r_d.pend ? ST_IDLE_SI : ST_IDLE_S);
        r_d.intrq = r_d.pend && r_d.sel && !r_d.nien;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= (DEV_ID == 1'b0) ? ST_IDLE_S : ST_IDLE_NS;
            r_q.status <= SB_RDY;
            r_q.sel    <= (DEV_ID == 1'b0);
            r_q.nien   <= 1'b0;
            r_q.pend   <= 1'b0;
            r_q.intrq  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign status = r_q.status;
    assign intrq  = r_q.intrq;

    // R4
    bsy_drq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[7] && status[3]));

    // R6
    stat_rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !intrq);

    // R7
    deselect_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && sel_dev != DEV_ID) |=> !intrq);

    // R8
    nien_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.nien |-> !intrq);

    // R3
    bad_cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE_S && cmd_wr && kind == CK_BAD && !ctl_wr && !sel_wr)
        |=> (status == (SB_RDY | SB_ERR)));

endmodule

// File: tb/ata_dev_engine_tb.sv
`timescale 1ns/1ps
module ata_dev_engine_tb;

    localparam int SECT = 8;
    localparam int MAXS = 4;
    localparam int WORD = 2;
    localparam int SW   = $clog2(MAXS);
    localparam int CW   = $clog2(MAXS * SECT + 1);
    localparam int BW   = $clog2(SECT + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stat_rd = 0, cmd_wr = 0, cmd_lba = 0, sel_wr = 0, sel_dev = 0;
    logic ctl_wr = 0, ctl_srst = 0, ctl_nien = 0, data_rd = 0, data_wr = 0;
    logic media_ready = 0, dma_done = 0;
    logic [7:0]    cmd_op = '0;
    logic [SW-1:0] cmd_seccnt = '0;
    logic [7:0]    status;
    logic          intrq;
    logic [CW-1:0] cmd_left;
    logic [BW-1:0] blk_left;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    int es;

    always #2 clk = ~clk;

    ata_dev_engine #(.SECT_BYTES(SECT), .MAX_SECT(MAXS), .WORD_BYTES(WORD), .DEV_ID(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
        .cmd_seccnt(cmd_seccnt), .cmd_lba(cmd_lba), .sel_wr(sel_wr), .sel_dev(sel_dev),
        .ctl_wr(ctl_wr), .ctl_srst(ctl_srst), .ctl_nien(ctl_nien), .data_rd(data_rd),
        .data_wr(data_wr), .media_ready(media_ready), .dma_done(dma_done),
        .status(status), .intrq(intrq), .cmd_left(cmd_left), .blk_left(blk_left)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int f_acc(input int s);  return (s | 'h80) & ~'h29; endfunction
    function automatic int f_rdy(input int s);  return (s & ~'h80) | 'h08; endfunction

    task automatic t_stat;  stat_rd = 1; @(negedge clk); stat_rd = 0; endtask
    task automatic t_rd;    data_rd = 1; @(negedge clk); data_rd = 0; endtask
    task automatic t_wr;    data_wr = 1; @(negedge clk); data_wr = 0; endtask
    task automatic t_ready; media_ready = 1; @(negedge clk); media_ready = 0; endtask
    task automatic t_dma;   dma_done = 1; @(negedge clk); dma_done = 0; endtask
    task automatic t_sel(input logic d);
        sel_wr = 1; sel_dev = d; @(negedge clk); sel_wr = 0;
    endtask
    task automatic t_ctl(input logic srst, input logic nien);
        ctl_wr = 1; ctl_srst = srst; ctl_nien = nien; @(negedge clk); ctl_wr = 0;
    endtask
    task automatic t_cmd(input logic [7:0] op, input int cnt, input logic lba);
        cmd_wr = 1; cmd_op = op; cmd_seccnt = SW'(cnt); cmd_lba = lba;
        @(negedge clk); cmd_wr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int left, nsec, held;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "status", int'(status), 'h40);
        chk("R1", "intrq", int'(intrq), 0);
        chk("R1", "cmd_left", int'(cmd_left), 0);
        chk("R1", "blk_left", int'(blk_left), 0);
        es = 'h40;

        // PIO data-in sweep over counts and interrupt enable
        for (int ni = 0; ni < 2; ni++) begin
            for (int c = 0; c < MAXS; c++) begin
                t_ctl(0, ni[0]);
                nsec = (c == 0) ? MAXS : c;
                t_cmd('h20, c, 1);
                es = f_acc(es);
                chk("R2", "pio-in status", int'(status), es);
                chk("R2", "pio-in cmd_left", int'(cmd_left), nsec * SECT);
                left = nsec * SECT;
                for (int b = 0; b < nsec; b++) begin
                    t_ready;
                    es = f_rdy(es);
                    chk("R4", "in ready status", int'(status), es);
                    chk("R4", "in blk_left", int'(blk_left), SECT);
                    chk("R5", "in block intrq", int'(intrq), (ni == 0) ? 1 : 0);
                    if (ni == 0) begin
                        t_stat;
                        chk("R6", "intrq after status read", int'(intrq), 0);
                    end
                    for (int w = 0; w < SECT / WORD; w++) begin
                        t_rd;
                        left -= WORD;
                        chk("R5", "in cmd_left", int'(cmd_left), left);
                    end
                    es = (b == nsec - 1) ? 'h50 : ((es | 'h80) & ~'h08);
                    chk("R5", "in block end status", int'(status), es);
                    chk("R5", "in block end intrq", int'(intrq), 0);
                end
            end
        end

        // PIO data-out sweep
        for (int ni = 0; ni < 2; ni++) begin
            for (int c = 0; c < MAXS; c++) begin
                t_ctl(0, ni[0]);
                nsec = (c == 0) ? MAXS : c;
                t_cmd('h30, c, 1);
                es = f_acc(es);
                chk("R2", "pio-out status", int'(status), es);
                left = nsec * SECT;
                for (int b = 0; b < nsec; b++) begin
                    t_ready;
                    es = f_rdy(es);
                    chk("R11", "out ready status", int'(status), es);
                    chk("R11", "out ready intrq", int'(intrq), (b != 0 && ni == 0) ? 1 : 0);
                    if (intrq) t_stat;
                    for (int w = 0; w < SECT / WORD; w++) begin
                        t_wr;
                        left -= WORD;
                        chk("R5", "out cmd_left", int'(cmd_left), left);
                    end
                    es = (es | 'h90) & ~'h08;
                    chk("R11", "out block end status", int'(status), es);
                end
                t_ready;
                es = 'h50;
                chk("R11", "out complete status", int'(status), es);
                chk("R11", "out complete intrq", int'(intrq), (ni == 0) ? 1 : 0);
                t_stat;
            end
        end

        // DMA and select handling
        t_ctl(0, 0);
        t_cmd('hC8, 2, 1);
        es = f_acc(es);
        chk("R2", "dma status", int'(status), es);
        t_ready;
        es = f_rdy(es);
        chk("R12", "dma ready status", int'(status), es);
        t_dma;
        es = 'h50;
        chk("R12", "dma done status", int'(status), es);
        chk("R12", "dma done intrq", int'(intrq), 1);
        t_sel(1);
        chk("R7", "deselect intrq", int'(intrq), 0);
        held = int'(cmd_left);
        t_cmd('h20, 1, 1);
        chk("R10", "unselected cmd status", int'(status), es);
        chk("R10", "unselected cmd_left", int'(cmd_left), held);
        t_sel(0);
        chk("R7", "reselect intrq", int'(intrq), 1);
        t_stat;
        chk("R6", "status read intrq", int'(intrq), 0);
        t_sel(1);
        t_sel(0);
        chk("R7", "reselect no pending", int'(intrq), 0);

        // interrupt disable discards pending
        t_cmd('hCA, 1, 1);
        es = f_acc(es);
        t_ready;
        t_dma;
        es = 'h50;
        chk("R12", "dma write intrq", int'(intrq), 1);
        t_ctl(0, 1);
        chk("R8", "nien drops intrq", int'(intrq), 0);
        t_ctl(0, 0);
        chk("R8", "pending discarded", int'(intrq), 0);

        // bad opcode and non-LBA
        t_cmd('h99, 1, 1);
        es = 'h41;
        chk("R3", "bad opcode status", int'(status), es);
        t_ready;
        chk("R3", "bad opcode no data phase", int'(status), es);
        chk("R3", "bad opcode intrq", int'(intrq), 0);
        t_cmd('h20, 1, 0);
        chk("R3", "non-LBA status", int'(status), es);
        t_cmd('h20, 1, 1);
        es = f_acc(es);
        chk("R2", "accept clears error", int'(status), es);

        // software reset mid-transfer
        t_ready;
        es = f_rdy(es);
        t_ctl(1, 0);
        es = (es | 'h80) & ~'h08;
        chk("R9", "srst status", int'(status), es);
        chk("R9", "srst cmd_left", int'(cmd_left), 0);
        chk("R9", "srst blk_left", int'(blk_left), 0);
        t_rd;
        chk("R9", "srst ignores data", int'(cmd_left), 0);
        t_cmd('h30, 1, 1);
        chk("R9", "srst ignores cmd", int'(status), es);
        t_ctl(0, 0);
        es = 'h40;
        chk("R9", "srst release status", int'(status), es);
        chk("R9", "srst release intrq", int'(intrq), 0);

        // busy ignores new command
        t_cmd('h30, 3, 1);
        es = f_acc(es);
        chk("R2", "post-reset accept", int'(status), es);
        chk("R2", "post-reset cmd_left", int'(cmd_left), 3 * SECT);
        t_cmd('h20, 1, 1);
        chk("R10", "busy cmd_left", int'(cmd_left), 3 * SECT);
        chk("R10", "busy status", int'(status), es);
        t_ctl(1, 0);
        t_ctl(0, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

endmodule